// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Limit Check

This block sequences a 10-bit successive-approximation converter. It drives a code onto an external DAC, reads a single comparator bit back, and controls the sample/hold line. When the DAC code is greater than the analog input, the comparator bit `cmp_in` is high. The block has two operations. A full conversion is a most-significant-bit-first binary search that delivers the input as a 10-bit code. A limit check applies a lower code and then an upper code, and reports whether the input sits inside that window, without running the search.

Raising `enable` first runs a settling wait, during which the DAC stays parked at midpoint with hold low. After the wait the block runs one throw-away conversion, and only then reports `ready`. Each operation starts with a sample phase: hold is low and the DAC is held at midpoint. Hold then rises for the comparison steps. Every result or set of window flags is announced by a one-clock `done` pulse.

Top module: `sar_ctrl`

## Requirements
- R1: Under synchronous active-low reset, `hold` is low, `dac_code` is 0x200, `done` and `ready` are low, `result` is 0, and the block is idle.
- R2: After `enable` rises, `hold` stays low and `dac_code` stays 0x200 for at least SETTLE_CYCLES clocks. The first comparison code appears on the (SETTLE_CYCLES+SAMPLE_CYCLES+3)th clock edge counted from the edge that first sees `enable` high.
- R3: After the settling wait, one dummy conversion runs: hold is high for exactly 20 clocks (10 comparisons). It produces no `done` pulse and leaves `result` unchanged. `ready` rises afterwards.
- R4: A conversion (`mode`=0) tests bits from bit 9 down to bit 0. For each bit it applies the decided bits with the tested bit set to 1. It keeps the bit when `cmp_in` is low (input at or above the code) and clears it otherwise, so `result` equals the input code for every input 0..1023.
- R5: Whenever `hold` is low, `dac_code` equals 0x200.
- R6: Each comparison code is held for two clocks, and `cmp_in` is sampled on the second edge. `done` for a conversion arrives on the (SAMPLE_CYCLES+22)th edge counted from the edge that accepts `start`. For a limit check it arrives on the (SAMPLE_CYCLES+6)th edge.
- R7: A limit check (`mode`=1) applies `lo_code` for two clocks and then `hi_code` for two clocks. `lower_fail` is set when `cmp_in` was high at the lower code. `upper_fail` is set when `cmp_in` was low at the upper code. `win_pass` is set only when neither fails, that is when lo_code <= input < hi_code.
- R8: `done` lasts exactly one clock. `result` and the window flags are updated with it and hold their values until the next delivery.
- R9: A `start` that arrives while `ready` is low is ignored: the running operation and its mode are unaffected, and no extra `done` follows.
- R10: Lowering `enable` returns the block to idle on the next clock (`hold` low, `dac_code` 0x200, `ready` low). Raising it again repeats the settling wait and the dummy conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter enable level |
| start | input | 1 | Start pulse, accepted only while `ready` |
| mode | input | 1 | 0 = conversion, 1 = limit check |
| lo_code | input | 10 | Lower limit code for the limit check |
| hi_code | input | 10 | Upper limit code for the limit check |
| cmp_in | input | 1 | Comparator bit, high when DAC code exceeds the input |
| dac_code | output | 10 | Code driven to the DAC |
| hold | output | 1 | High = hold, low = sample |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | One-clock delivery strobe |
| result | output | 10 | Last delivered conversion code |
| lower_fail | output | 1 | Input was below the lower limit |
| upper_fail | output | 1 | Input was not below the upper limit |
| win_pass | output | 1 | Both limit checks succeeded |

## Verification
The bench builds the block with WIDTH 10, SETTLE_CYCLES 4 and SAMPLE_CYCLES 2. The short settling and sample phases make a conversion cost about 26 clocks. That makes it affordable to convert every one of the 1024 input codes and to sweep all 1024 inputs through a fixed limit window. Around those sweeps, the bench also checks exact latencies, the edge cases where the input equals a limit, starts issued while busy, and dropping `enable` mid-conversion.

// File: rtl/sar_pkg.sv
// Package sar_pkg
// Shared controller state encoding for the successive-approximation controller.
// Assumes: a single clock domain; no other block decodes these values.
package sar_pkg;
    typedef enum logic [3:0] {
        ST_OFF,
        ST_SETTLE,
        ST_SAMPLE,
        ST_SET,
        ST_CMP,
        ST_READY,
        ST_WLO_SET,
        ST_WLO_CMP,
        ST_WHI_SET,
        ST_WHI_CMP
    } sar_state_t;
endpackage

// File: rtl/sar_wait_timer.sv
// Module sar_wait_timer
// Down-counter used for the settling wait and the sample phase. It is loaded
// with a count and decrements to zero; expired is high while it sits at zero.
// Assumes: load and counting never happen in the same cycle as a reload race.
module sar_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down toward zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/sar_bit_search.sv
// Module sar_bit_search
// Successive-approximation register. After clear it tests the MSB. Each step
// keeps the tested bit when the comparator is low (input at or above the code)
// and moves the pointer one bit down.
// Assumes: cmp_hi is valid whenever step is high.
module sar_bit_search #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] resolved,
    output logic             last
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] mask_q;

    // Decided bits and bit pointer: reset on clear, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (clear) begin
            code_q <= '0;
            mask_q <= TOP_BIT;
        end else if (step) begin
            if (!cmp_hi)
                code_q <= code_q | mask_q;
            mask_q <= mask_q >> 1;
        end
    end

    assign trial    = code_q | mask_q;
    assign resolved = cmp_hi ? code_q : trial;
    assign last     = mask_q[0];

    // R4
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));
    // R4
    undecided_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> ((code_q & (mask_q | (mask_q - 1'b1))) == '0));
endmodule

// File: rtl/sar_window_eval.sv
// Module sar_window_eval
// Records the comparator at the lower limit code, then at the upper one. On
// the second sample it publishes the fail flags and the pass flag.
// Assumes: take_lo always precedes take_hi within one limit check.
module sar_window_eval (
    input  logic clk,
    input  logic rst_n,
    input  logic take_lo,
    input  logic take_hi,
    input  logic cmp_hi,
    output logic lower_fail,
    output logic upper_fail,
    output logic win_pass
);
    logic lo_bad_q;

    // Remember whether the lower limit code already exceeded the input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_bad_q <= 1'b0;
        else if (take_lo)
            lo_bad_q <= cmp_hi;
    end

    // Publish the three flags together at the end of the upper check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower_fail <= 1'b0;
            upper_fail <= 1'b0;
            win_pass   <= 1'b0;
        end else if (take_hi) begin
            lower_fail <= lo_bad_q;
            upper_fail <= !cmp_hi;
            win_pass   <= !lo_bad_q && cmp_hi;
        end
    end

    // R7
    pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_pass |-> (!lower_fail && !upper_fail));
    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_hi |=> ($stable(lower_fail) && $stable(upper_fail) && $stable(win_pass)));
endmodule

// File: rtl/sar_ctrl.sv
// Module sar_ctrl
// Top-level sequencer for the successive-approximation converter. Handles the
// settling wait and the dummy conversion after enable, the sample phase,
// binary-search conversions and two-step limit checks.
// Assumes: cmp_in is high when dac_code exceeds the analog input, and the
// external comparator settles within one clock of a code change.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH         = 10,
    parameter int SETTLE_CYCLES = 25,
    parameter int SAMPLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             mode,
    input  logic [WIDTH-1:0] lo_code,
    input  logic [WIDTH-1:0] hi_code,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             hold,
    output logic             ready,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             lower_fail,
    output logic             upper_fail,
    output logic             win_pass
);
    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};
    localparam int TMAX  = (SETTLE_CYCLES > SAMPLE_CYCLES) ? SETTLE_CYCLES : SAMPLE_CYCLES;
    localparam int CNT_W = $clog2(TMAX + 1) < 1 ? 1 : $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_VAL = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] SAMPLE_VAL = CNT_W'(SAMPLE_CYCLES);

    sar_state_t       state_q, state_d;
    logic             dummy_q, mode_q, done_q;
    logic [WIDTH-1:0] lo_q, hi_q, result_q;

    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             srch_clear, srch_step, srch_last;
    logic [WIDTH-1:0] srch_trial, srch_resolved;
    logic             take_lo, take_hi, fin_conv;

    sar_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sar_bit_search #(.WIDTH(WIDTH)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (srch_clear),
        .step     (srch_step),
        .cmp_hi   (cmp_in),
        .trial    (srch_trial),
        .resolved (srch_resolved),
        .last     (srch_last)
    );

    sar_window_eval u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_lo    (take_lo),
        .take_hi    (take_hi),
        .cmp_hi     (cmp_in),
        .lower_fail (lower_fail),
        .upper_fail (upper_fail),
        .win_pass   (win_pass)
    );

    // Next-state and per-cycle strobes for the sequencer.
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = SAMPLE_VAL;
        srch_clear = 1'b0;
        srch_step  = 1'b0;
        take_lo    = 1'b0;
        take_hi    = 1'b0;
        fin_conv   = 1'b0;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_VAL;
                end
                ST_SETTLE: if (tmr_expired) begin
                    state_d  = ST_SAMPLE;
                    tmr_load = 1'b1;
                end
                ST_SAMPLE: if (tmr_expired) begin
                    if (dummy_q || !mode_q) begin
                        state_d    = ST_SET;
                        srch_clear = 1'b1;
                    end else begin
                        state_d = ST_WLO_SET;
                    end
                end
                ST_SET: state_d = ST_CMP;
                ST_CMP: begin
                    srch_step = 1'b1;
                    if (srch_last) begin
                        state_d  = ST_READY;
                        fin_conv = 1'b1;
                    end else begin
                        state_d = ST_SET;
                    end
                end
                ST_READY: if (start) begin
                    state_d  = ST_SAMPLE;
                    tmr_load = 1'b1;
                end
                ST_WLO_SET: state_d = ST_WLO_CMP;
                ST_WLO_CMP: begin
                    take_lo = 1'b1;
                    state_d = ST_WHI_SET;
                end
                ST_WHI_SET: state_d = ST_WHI_CMP;
                ST_WHI_CMP: begin
                    take_hi = 1'b1;
                    state_d = ST_READY;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register, dummy marker and delivery strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dummy_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (fin_conv && !dummy_q) || take_hi;
            if (state_q == ST_OFF && state_d == ST_SETTLE)
                dummy_q <= 1'b1;
            else if (fin_conv)
                dummy_q <= 1'b0;
        end
    end

    // Capture the operation request when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (enable && state_q == ST_READY && start) begin
            mode_q <= mode;
            lo_q   <= lo_code;
            hi_q   <= hi_code;
        end
    end

    // Deliver a conversion result unless it is the discarded dummy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (fin_conv && !dummy_q)
            result_q <= srch_resolved;
    end

    // Hold is high only during comparison steps; DAC is at midpoint otherwise.
    always_comb begin
        hold     = 1'b1;
        dac_code = MID;
        unique case (state_q)
            ST_SET, ST_CMP:         dac_code = srch_trial;
            ST_WLO_SET, ST_WLO_CMP: dac_code = lo_q;
            ST_WHI_SET, ST_WHI_CMP: dac_code = hi_q;
            default:                hold     = 1'b0;
        endcase
    end

    assign ready  = (state_q == ST_READY);
    assign done   = done_q;
    assign result = result_q;

    // R5
    hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (dac_code == MID));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_q |-> !done);
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READY) |=> $stable(mode_q));
    // R6
    cmp_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP || state_q == ST_WLO_CMP || state_q == ST_WHI_CMP) |-> $stable(dac_code));
    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hold && !ready));
endmodule

// File: tb/sar_ctrl_test.sv
// Bench for sar_ctrl: the comparator is a threshold on an integer input code.
module sar_ctrl_test;
    localparam int W   = 10;
    localparam int SET = 4;
    localparam int SMP = 2;
    localparam int MIDV = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0, start = 1'b0, mode = 1'b0;
    logic [W-1:0] lo_code = '0, hi_code = '0;
    logic         cmp_in;
    logic [W-1:0] dac_code, result;
    logic         hold, ready, done, lower_fail, upper_fail, win_pass;
    int           vin = 0;
    int           vectors = 0, errs = 0;
    int           mon_r5 = 0, mon_r8 = 0;
    bit           prev_done = 1'b0;

    always #4 clk = ~clk;

    assign cmp_in = (int'(dac_code) > vin);

    sar_ctrl #(.WIDTH(W), .SETTLE_CYCLES(SET), .SAMPLE_CYCLES(SMP)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .mode(mode),
        .lo_code(lo_code), .hi_code(hi_code), .cmp_in(cmp_in),
        .dac_code(dac_code), .hold(hold), .ready(ready), .done(done),
        .result(result), .lower_fail(lower_fail), .upper_fail(upper_fail),
        .win_pass(win_pass)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Continuous monitors for midpoint-while-sampling and single-cycle done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!hold && int'(dac_code) != MIDV) mon_r5++;
            if (done && prev_done) mon_r8++;
        end
        prev_done = done;
    end

    // Issue one operation; report latency, codes at hold cycles 0 and 2, hold count.
    task automatic run_op(input bit m, input int v, input int lo, input int hi,
                          input int inject, output int lat, output int c0,
                          output int c2, output int hcnt);
        int n;
        vin = v; mode = m; lo_code = W'(lo); hi_code = W'(hi);
        start = 1'b1;
        c0 = -1; c2 = -1; hcnt = 0;
        @(posedge clk); n = 1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 200) begin
            if (hold) begin
                if (hcnt == 0) c0 = int'(dac_code);
                if (hcnt == 2) c2 = int'(dac_code);
                hcnt++;
            end
            if (n == inject) begin start = 1'b1; mode = ~m; end
            else start = 1'b0;
            @(posedge clk); n++;
            @(negedge clk);
        end
        start = 1'b0;
        lat = n;
    endtask

    task automatic bring_up(input string tag);
        int n, hc;
        bit saw_done;
        enable = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk);
        while (!hold && n < 200) begin @(posedge clk); n++; @(negedge clk); end
        chk(n >= SET + 1, {tag, " R2 settle at least SETTLE_CYCLES"}, n, SET + 1);
        chk(n == SET + SMP + 3, {tag, " R2 first code edge"}, n, SET + SMP + 3);
        hc = 0; saw_done = 1'b0;
        while (!ready && hc < 200) begin
            if (hold) hc++;
            if (done) saw_done = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        chk(hc == 20, {tag, " R3 dummy hold clocks"}, hc, 20);
        chk(!saw_done, {tag, " R3 no done on dummy"}, int'(saw_done), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin : main
        int lat, c0, c2, hc, exp_lf, exp_uf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!hold, "R1 hold low", int'(hold), 0);
        chk(int'(dac_code) == MIDV, "R1 dac midpoint", int'(dac_code), MIDV);
        chk(!done && !ready, "R1 done/ready low", int'(done) + int'(ready), 0);
        chk(result == '0, "R1 result zero", int'(result), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!ready && !hold, "R1 idle until enable", int'(ready), 0);

        bring_up("first enable");
        chk(result == '0, "R3 result unchanged by dummy", int'(result), 0);

        // R4 R6: exhaustive conversion sweep
        for (int v = 0; v < 1024; v++) begin
            run_op(1'b0, v, 0, 0, -1, lat, c0, c2, hc);
            chk(int'(result) == v, "R4 conversion result", int'(result), v);
            chk(lat == SMP + 22, "R6 conversion latency", lat, SMP + 22);
            if (v == 0 || v == 1023)
                chk(c0 == MIDV, "R4 first trial is MSB", c0, MIDV);
        end

        // R8: result holds after done
        run_op(1'b0, 555, 0, 0, -1, lat, c0, c2, hc);
        vin = 10;
        repeat (10) @(negedge clk);
        chk(int'(result) == 555 && !done, "R8 result held", int'(result), 555);

        // R7: sweep input through a window, plus edge windows
        for (int v = 0; v < 1024; v++) begin
            run_op(1'b1, v, 300, 700, -1, lat, c0, c2, hc);
            exp_lf = (300 > v) ? 1 : 0;
            exp_uf = (700 <= v) ? 1 : 0;
            chk(int'(lower_fail) == exp_lf, "R7 lower_fail", int'(lower_fail), exp_lf);
            chk(int'(upper_fail) == exp_uf, "R7 upper_fail", int'(upper_fail), exp_uf);
            chk(int'(win_pass) == int'(exp_lf == 0 && exp_uf == 0), "R7 win_pass",
                int'(win_pass), int'(exp_lf == 0 && exp_uf == 0));
            if (v == 300) begin
                chk(c0 == 300 && c2 == 700, "R7 lower code then upper", c0 * 1024 + c2, 300 * 1024 + 700);
                chk(hc == 4, "R7 four hold clocks", hc, 4);
                chk(lat == SMP + 6, "R6 window latency", lat, SMP + 6);
            end
        end
        run_op(1'b1, 1023, 0, 1023, -1, lat, c0, c2, hc);
        chk(!lower_fail && upper_fail && !win_pass, "R7 top code fails upper",
            int'(upper_fail), 1);
        run_op(1'b1, 400, 400, 400, -1, lat, c0, c2, hc);
        chk(!lower_fail && upper_fail && !win_pass, "R7 empty window",
            int'(win_pass), 0);
        run_op(1'b1, 0, 0, 1, -1, lat, c0, c2, hc);
        chk(win_pass, "R7 narrow window passes", int'(win_pass), 1);

        // R9: start during conversion ignored
        run_op(1'b0, 777, 0, 0, 5, lat, c0, c2, hc);
        chk(int'(result) == 777, "R9 result unaffected", int'(result), 777);
        chk(lat == SMP + 22, "R9 latency unaffected", lat, SMP + 22);
        begin
            int extra;
            extra = 0;
            repeat (30) begin @(negedge clk); if (done || !ready) extra++; end
            chk(extra == 0, "R9 no extra operation", extra, 0);
        end

        // R10: drop enable mid-conversion, then re-enable
        vin = 123; mode = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!hold && !ready && int'(dac_code) == MIDV, "R10 idle after disable",
            int'(hold) + int'(ready), 0);
        repeat (5) @(negedge clk);
        chk(int'(result) == 777, "R10 result kept", int'(result), 777);
        // start while disabled is ignored (R9)
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(!hold && !ready, "R9 start ignored while off", int'(hold), 0);
        bring_up("re-enable R10");
        run_op(1'b0, 321, 0, 0, -1, lat, c0, c2, hc);
        chk(int'(result) == 321, "R10 conversion after re-enable", int'(result), 321);

        chk(mon_r5 == 0, "R5 midpoint whenever hold low", mon_r5, 0);
        chk(mon_r8 == 0, "R8 done single cycle", mon_r8, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule